// File: doc/BRIEF.md
# Prefetch Idle Chip-Select Release Timer

When a serial flash is read through a memory-mapped window, the read path keeps prefetching into a local buffer and keeps the flash selected (chip select low), so that the next sequential host read is served quickly. A flash that stays selected draws more current than one that is deselected. This block watches that path and cuts the waste. Once the prefetch buffer has filled, it counts serial-clock cycles. If a programmed number of them pass without a host access, it asks the sequencer to raise chip select.

Expiry also sets a sticky timeout flag. Only a write-one clear strobe resets that flag, and the flag can raise an interrupt. The timer acts only while the controller is in memory-mapped mode and the timer is enabled. Its enable and its 16-bit period are taken into a shadow register only while the controller is idle. After a release, the next host access drops the release request, and the prefetch sequence starts again with chip select low.

Top module: `prefetch_idle_release`

## Requirements
- R1: The timer is armed only while the latched enable is 1 and `mmap_mode` is 1. While it is not armed, `cs_release` is 0 from the next cycle on, and the timeout flag is never set, however long the buffer stays full.
- R2: Counting begins in the first cycle in which `buf_full` is sampled high. With a latched period P ≥ 1 and no host access, `cs_release` rises exactly P clock edges after that first full cycle. A period of 0 behaves as a period of 1.
- R3: The counter stays at zero while `buf_full` is low. A gap of even one cycle in `buf_full` restarts the full window.
- R4: A `host_access` pulse before expiry resets the count, so that P new idle cycles are needed.
- R5: After expiry, `cs_release` stays at 1 until a host access or a disarm. It stays at 1 even if the flag is cleared. A host access drops it at the next edge, and a new window of P cycles then starts.
- R6: Expiry sets `timeout_flag`. The flag stays set until a cycle with `flag_clr` = 1. If an expiry and a clear occur in the same cycle, the expiry wins and the flag stays at 1.
- R7: `timeout_irq` is 1 exactly when `timeout_flag` = 1 and `irq_en` = 1. It follows `irq_en` in the same cycle.
- R8: `tmr_en` and `period` are latched only in cycles with `ctrl_busy` = 0. Changes made while `ctrl_busy` = 1 have no effect on the counting.
- R9: The counter does not wrap at the full-scale period 65535: the release comes exactly 65535 edges after the buffer fills.
- R10: Disarming the timer (`mmap_mode` low) while the release is asserted drops `cs_release` at the next edge. Re-arming with the buffer still full starts a fresh window.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Serial-clock-domain clock |
| rst | input | 1 | Synchronous active-high reset |
| ctrl_busy | input | 1 | Controller busy; configuration is frozen while high |
| tmr_en | input | 1 | Timer enable request |
| period | input | 16 | Idle period in clock cycles |
| irq_en | input | 1 | Timeout interrupt enable |
| mmap_mode | input | 1 | Controller is in memory-mapped read mode |
| buf_full | input | 1 | Prefetch buffer is full |
| host_access | input | 1 | Host access strobe on the mapped window |
| flag_clr | input | 1 | Write-one clear strobe for the timeout flag |
| cs_release | output | 1 | Request to the sequencer to raise chip select |
| timeout_flag | output | 1 | Sticky timeout flag |
| timeout_irq | output | 1 | Timeout interrupt |

## Verification
The bench builds the block with its default 16-bit counter width. Most scenarios use small periods (0, 3, 4 and 5), so that the edge-exact placement of the release, the restarts and the races can each be observed within a few cycles. One scenario programs the full-scale period of 65535. This brings the top of the counter range within reach and shows that the comparison does not wrap, without a separate narrow build.

// File: rtl/idle_rel_pkg.sv
package idle_rel_pkg;

    localparam int unsigned DEF_CNT_W = 16;

    // Chip-select side state of the controller
    typedef enum logic [0:0] {
        CS_HELD     = 1'b0,
        CS_RELEASED = 1'b1
    } cs_state_e;

    // Latched configuration, width fixed at the default
    typedef struct packed {
        logic                 en;
        logic [DEF_CNT_W-1:0] period;
    } idle_cfg_t;

    // The window is complete when the edge now being taken is the
    // period-th one; a period of zero completes on the first edge.
    function automatic logic window_done(input logic [31:0] cnt_v,
                                         input logic [31:0] per_v);
        return (cnt_v + 32'd1) >= per_v;
    endfunction

endpackage

// File: rtl/idle_cfg_shadow.sv
module idle_cfg_shadow
    import idle_rel_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_busy,
    input  logic             tmr_en,
    input  logic [CNT_W-1:0] period,
    output logic             en_q,
    output logic [CNT_W-1:0] period_q
);

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q     <= 1'b0;
            period_q <= '0;
        end else if (!ctrl_busy) begin
            en_q     <= tmr_en;
            period_q <= period;
        end
    end

    AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
        ctrl_busy |=> ($stable(en_q) && $stable(period_q))); // R8

endmodule

// File: rtl/idle_counter.sv
module idle_counter
    import idle_rel_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             count_en,
    input  logic [CNT_W-1:0] period_q,
    output logic [CNT_W-1:0] cnt,
    output logic             expire
);

    assign expire = count_en && window_done(32'(cnt), 32'(period_q));

    always_ff @(posedge clk) begin
        if (rst || !count_en || expire) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
        count_en && !expire |=> cnt != '0); // R9

endmodule

// File: rtl/idle_release_ctl.sv
module idle_release_ctl
    import idle_rel_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic armed,
    input  logic host_access,
    input  logic expire,
    input  logic flag_clr,
    input  logic irq_en,
    output logic cs_release,
    output logic timeout_flag,
    output logic timeout_irq
);

    cs_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        if (!armed || host_access) begin
            state_d = CS_HELD;
        end else if (expire) begin
            state_d = CS_RELEASED;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q      <= CS_HELD;
            timeout_flag <= 1'b0;
        end else begin
            state_q <= state_d;
            if (expire) begin
                timeout_flag <= 1'b1;
            end else if (flag_clr) begin
                timeout_flag <= 1'b0;
            end
        end
    end

    assign cs_release  = (state_q == CS_RELEASED);
    assign timeout_irq = timeout_flag && irq_en;

    AST_DISARM_DROPS: assert property (@(posedge clk) disable iff (rst)
        !armed |=> !cs_release); // R1
    AST_ACCESS_RESUMES: assert property (@(posedge clk) disable iff (rst)
        host_access |=> !cs_release); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (rst)
        timeout_flag && !flag_clr |=> timeout_flag); // R6
    AST_REL_FROM_EXPIRY: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_release) |-> $past(expire)); // R2

endmodule

// File: rtl/prefetch_idle_release.sv
module prefetch_idle_release
    import idle_rel_pkg::*;
#(
    parameter int unsigned CNT_W = DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ctrl_busy,
    input  logic             tmr_en,
    input  logic [CNT_W-1:0] period,
    input  logic             irq_en,
    input  logic             mmap_mode,
    input  logic             buf_full,
    input  logic             host_access,
    input  logic             flag_clr,
    output logic             cs_release,
    output logic             timeout_flag,
    output logic             timeout_irq
);

    logic             en_q;
    logic [CNT_W-1:0] period_q;
    logic [CNT_W-1:0] cnt;
    logic             expire;
    logic             armed;
    logic             count_en;

    idle_cfg_shadow #(.CNT_W(CNT_W)) u_cfg (
        .clk       (clk),
        .rst       (rst),
        .ctrl_busy (ctrl_busy),
        .tmr_en    (tmr_en),
        .period    (period),
        .en_q      (en_q),
        .period_q  (period_q)
    );

    assign armed    = en_q && mmap_mode;
    assign count_en = armed && buf_full && !host_access && !cs_release;

    idle_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .count_en (count_en),
        .period_q (period_q),
        .cnt      (cnt),
        .expire   (expire)
    );

    idle_release_ctl u_ctl (
        .clk          (clk),
        .rst          (rst),
        .armed        (armed),
        .host_access  (host_access),
        .expire       (expire),
        .flag_clr     (flag_clr),
        .irq_en       (irq_en),
        .cs_release   (cs_release),
        .timeout_flag (timeout_flag),
        .timeout_irq  (timeout_irq)
    );

    AST_HOLD_NOT_FULL: assert property (@(posedge clk) disable iff (rst)
        !buf_full |=> cnt == '0); // R3
    AST_ACCESS_CLEARS: assert property (@(posedge clk) disable iff (rst)
        host_access |=> cnt == '0); // R4

endmodule

// File: tb/test_prefetch_idle_release.sv
module test_prefetch_idle_release;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctrl_busy = 1'b0;
    logic        tmr_en = 1'b0;
    logic [15:0] period = 16'd0;
    logic        irq_en = 1'b0;
    logic        mmap_mode = 1'b0;
    logic        buf_full = 1'b0;
    logic        host_access = 1'b0;
    logic        flag_clr = 1'b0;
    logic        cs_release;
    logic        timeout_flag;
    logic        timeout_irq;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    prefetch_idle_release i_prefetch_idle_release (
        .clk          (clk),
        .rst          (rst),
        .ctrl_busy    (ctrl_busy),
        .tmr_en       (tmr_en),
        .period       (period),
        .irq_en       (irq_en),
        .mmap_mode    (mmap_mode),
        .buf_full     (buf_full),
        .host_access  (host_access),
        .flag_clr     (flag_clr),
        .cs_release   (cs_release),
        .timeout_flag (timeout_flag),
        .timeout_irq  (timeout_irq)
    );

    task automatic check(input string req, input string what,
                         input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0b expected=%0b", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic settle();
        buf_full = 1'b0; host_access = 1'b1; flag_clr = 1'b1;
        edges(1);
        host_access = 1'b0; flag_clr = 1'b0;
        edges(1);
    endtask

    task automatic set_cfg(input logic e, input logic [15:0] p);
        ctrl_busy = 1'b0; tmr_en = e; period = p;
        edges(1);
    endtask

    task automatic t_reset_state();
        rst = 1'b1;
        edges(2);
        rst = 1'b0;
        check("R1", "reset release", cs_release, 1'b0);
        check("R6", "reset flag", timeout_flag, 1'b0);
        check("R7", "reset irq", timeout_irq, 1'b0);
    endtask

    task automatic t_basic();
        settle(); mmap_mode = 1'b1; irq_en = 1'b1;
        set_cfg(1'b1, 16'd4);
        buf_full = 1'b1;
        edges(3);
        check("R2", "before P edges", cs_release, 1'b0);
        check("R6", "flag before expiry", timeout_flag, 1'b0);
        edges(1);
        check("R2", "at P edges", cs_release, 1'b1);
        check("R6", "flag at expiry", timeout_flag, 1'b1);
        check("R7", "irq enabled", timeout_irq, 1'b1);
        irq_en = 1'b0; #1;
        check("R7", "irq masked", timeout_irq, 1'b0);
        irq_en = 1'b1; #1;
        check("R7", "irq unmasked", timeout_irq, 1'b1);
        @(negedge clk);
        flag_clr = 1'b1; edges(1); flag_clr = 1'b0;
        check("R6", "flag cleared", timeout_flag, 1'b0);
        check("R5", "release survives clear", cs_release, 1'b1);
        edges(3);
        check("R6", "no re-set while released", timeout_flag, 1'b0);
        check("R5", "release held", cs_release, 1'b1);
    endtask

    task automatic t_gap();
        settle(); set_cfg(1'b1, 16'd5);
        buf_full = 1'b1; edges(3);
        buf_full = 1'b0; edges(1);
        buf_full = 1'b1; edges(4);
        check("R3", "gap restarts window", cs_release, 1'b0);
        edges(1);
        check("R3", "full window after gap", cs_release, 1'b1);
    endtask

    task automatic t_access_before();
        settle(); set_cfg(1'b1, 16'd5);
        buf_full = 1'b1; edges(3);
        host_access = 1'b1; edges(1); host_access = 1'b0;
        edges(4);
        check("R4", "access restarts count", cs_release, 1'b0);
        edges(1);
        check("R4", "expiry after restart", cs_release, 1'b1);
    endtask

    task automatic t_after_expiry();
        settle(); set_cfg(1'b1, 16'd3);
        buf_full = 1'b1; edges(3);
        check("R5", "expired", cs_release, 1'b1);
        edges(2);
        check("R5", "held without access", cs_release, 1'b1);
        host_access = 1'b1; edges(1); host_access = 1'b0;
        check("R5", "access drops release", cs_release, 1'b0);
        edges(2);
        check("R5", "new window running", cs_release, 1'b0);
        edges(1);
        check("R5", "new window expired", cs_release, 1'b1);
    endtask

    task automatic t_disarm();
        settle(); set_cfg(1'b1, 16'd3);
        buf_full = 1'b1; edges(3);
        check("R10", "expired before disarm", cs_release, 1'b1);
        mmap_mode = 1'b0; edges(1);
        check("R10", "disarm drops release", cs_release, 1'b0);
        edges(6);
        check("R1", "no release outside mapped mode", cs_release, 1'b0);
        mmap_mode = 1'b1; edges(2);
        check("R10", "rearm window running", cs_release, 1'b0);
        edges(1);
        check("R10", "rearm window expired", cs_release, 1'b1);
        settle(); set_cfg(1'b0, 16'd3);
        buf_full = 1'b1; edges(10);
        check("R1", "disabled no release", cs_release, 1'b0);
        check("R1", "disabled no flag", timeout_flag, 1'b0);
    endtask

    task automatic t_busy_freeze();
        settle(); set_cfg(1'b1, 16'd4);
        ctrl_busy = 1'b1; tmr_en = 1'b0; period = 16'd2;
        buf_full = 1'b1; edges(3);
        check("R8", "busy period change ignored", cs_release, 1'b0);
        edges(1);
        check("R8", "latched period used", cs_release, 1'b1);
        ctrl_busy = 1'b0; tmr_en = 1'b1;
    endtask

    task automatic t_race();
        settle(); set_cfg(1'b1, 16'd3);
        buf_full = 1'b1; edges(3);
        check("R6", "first expiry flag", timeout_flag, 1'b1);
        host_access = 1'b1; edges(1); host_access = 1'b0;
        edges(2);
        flag_clr = 1'b1; edges(1); flag_clr = 1'b0;
        check("R6", "expiry beats clear", timeout_flag, 1'b1);
        check("R2", "release at race edge", cs_release, 1'b1);
    endtask

    task automatic t_zero();
        settle(); set_cfg(1'b1, 16'd0);
        buf_full = 1'b1; edges(1);
        check("R2", "period zero acts as one", cs_release, 1'b1);
    endtask

    task automatic t_full_scale();
        settle(); set_cfg(1'b1, 16'hFFFF);
        buf_full = 1'b1; edges(65534);
        check("R9", "one edge before full scale", cs_release, 1'b0);
        edges(1);
        check("R9", "full scale expiry", cs_release, 1'b1);
    endtask

    initial begin
        @(negedge clk);
        t_reset_state();
        t_basic();
        t_gap();
        t_access_before();
        t_after_expiry();
        t_disarm();
        t_busy_freeze();
        t_race();
        t_zero();
        t_full_scale();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog run did not finish actual=hung expected=done");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule